// File: doc/BRIEF.md
# Four-Phase Handshake Bus Target

This block is a memory-mapped target on a 32-bit processor bus. The master presents a 30-bit word address (the byte address with its two low bits dropped), four byte-lane enables, a read/not-write flag and write data, then raises a master-enable strobe. The target answers with a registered acknowledge. Acknowledge stays high until the master drops master enable, and it falls on the next clock after that. A new access is taken only once both strobes are back low.

Behind the bus sit two 8-bit registers. The input word is at the device base and holds a registered sample of an external input port. The output word is at byte offset 4 (word index base + 1) and drives an external output port. Read data comes back zero-extended in byte lane 0. The data-in bus reads zero whenever no read is being acknowledged. The master-driven inputs are taken as synchronous to the target clock.

Top module: `hs_bus_target`

## Requirements
- R1: After reset, ack_o is 0, rdata_o is 0 and out_port_o is 0.
- R2: While me_i is 0, ack_o stays 0 and out_port_o does not change, whatever addr_i, rnw_i, be_i and wdata_i carry.
- R3: A read (rnw_i = 1) of word address BASE_WADDR, with me_i high, raises ack_o one clock later and presents {24'b0, in_port_i} on rdata_o. The in_port_i value must have been stable for the two preceding clocks.
- R4: A read of word address BASE_WADDR + 1 returns {24'b0, out_port_o} on rdata_o together with ack_o.
- R5: A write (rnw_i = 0) to BASE_WADDR + 1 with be_i[0] = 1 loads wdata_i[7:0] into out_port_o at the same edge that raises ack_o. wdata_i[31:8] and be_i[3:1] have no effect.
- R6: A write to BASE_WADDR + 1 with be_i[0] = 0 is acknowledged but leaves out_port_o unchanged.
- R7: A write to BASE_WADDR is acknowledged and changes neither out_port_o nor the input register.
- R8: Once raised, ack_o stays 1 for as long as me_i stays 1. It goes to 0 at the first clock edge that samples me_i low.
- R9: An access whose word address is neither BASE_WADDR nor BASE_WADDR + 1 never raises ack_o and does not change out_port_o, however long me_i is held.
- R10: While ack_o is high for a read, rdata_o holds the value captured at acceptance even if in_port_i changes. rdata_o is 0 whenever ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Target clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 30 | Word address (byte address bits 31..2) |
| be_i | input | 4 | Byte-lane enables, bit n marks lane n |
| rnw_i | input | 1 | 1 = read, 0 = write |
| me_i | input | 1 | Master enable strobe |
| wdata_i | input | 32 | Write data from the master |
| rdata_o | output | 32 | Read data to the master |
| ack_o | output | 1 | Registered acknowledge |
| in_port_i | input | 8 | External input port |
| out_port_o | output | 8 | External output port |

## Verification
The hardest situation to reach from the ports is a read that is already acknowledged while the sampled input keeps moving. It takes a master that holds enable high for several cycles after acknowledge and changes the input port during that hold. The bench's master task has a hold count for this. It is used for every read of the input word while in_port_i is swept through all 256 values, so the captured data can be checked for freezing. Every data value is also written under all 16 byte-enable patterns, and a set of near-miss addresses is driven with long enable holds.

// File: rtl/hs_target_pkg.sv
package hs_target_pkg;
  typedef enum logic [0:0] {HS_IDLE, HS_ACK} hs_state_e;
  typedef enum logic [1:0] {SEL_NONE, SEL_IN, SEL_OUT} hs_sel_e;
endpackage

// File: rtl/hs_addr_decode.sv
module hs_addr_decode
  import hs_target_pkg::*;
#(
  parameter int unsigned           ADDR_W     = 30,
  parameter logic [ADDR_W-1:0]     BASE_WADDR = 30'h0123_4560,
  parameter int unsigned           IN_WOFS    = 0,
  parameter int unsigned           OUT_WOFS   = 1
) (
  input  logic              me_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hs_sel_e           sel_o
);
  localparam logic [ADDR_W-1:0] IN_WADDR  = BASE_WADDR + ADDR_W'(IN_WOFS);
  localparam logic [ADDR_W-1:0] OUT_WADDR = BASE_WADDR + ADDR_W'(OUT_WOFS);

  // gated by me_i so settling addresses never decode
  always_comb begin
    sel_o = SEL_NONE;
    if (me_i) begin
      if (addr_i == IN_WADDR)       sel_o = SEL_IN;
      else if (addr_i == OUT_WADDR) sel_o = SEL_OUT;
    end
  end
endmodule

// File: rtl/hs_handshake_fsm.sv
module hs_handshake_fsm
  import hs_target_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic me_i,
  input  logic hit_i,
  output logic fire_o,
  output logic ack_o
);
  hs_state_e state_q, state_d;

  assign fire_o = (state_q == HS_IDLE) && me_i && hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (fire_o) state_d = HS_ACK;
      HS_ACK:  if (!me_i)  state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= (state_d == HS_ACK);
  end

  a_r2_no_ack_without_me: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(me_i));
  a_r8_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && me_i) |=> ack_o);
  a_r8_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !me_i) |=> !ack_o);
  a_r9_no_ack_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && !hit_i) |=> !ack_o);
endmodule

// File: rtl/hs_reg_file.sv
module hs_reg_file
  import hs_target_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  logic                ack_i,
  input  logic                me_i,
  input  logic                rnw_i,
  input  hs_sel_e             sel_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [REG_W-1:0]    in_port_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [REG_W-1:0]    out_port_o
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned LANES = REG_W / 8;
  localparam int unsigned PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0]  in_q;
  logic [7:0]        out_b [LANES];
  logic [DATA_W-1:0] rd_q;
  logic              wr_out;
  logic              unused_hi;

  assign wr_out    = fire_i && !rnw_i && (sel_i == SEL_OUT);
  assign unused_hi = ^{be_i[BE_W-1:LANES], wdata_i[DATA_W-1:REG_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= in_port_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                out_b[l] <= '0;
      else if (wr_out && be_i[l]) out_b[l] <= wdata_i[l*8 +: 8];
    end
    assign out_port_o[l*8 +: 8] = out_b[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (fire_i) begin
      if (!rnw_i)               rd_q <= '0;
      else if (sel_i == SEL_IN) rd_q <= {{PAD_W{1'b0}}, in_q};
      else                      rd_q <= {{PAD_W{1'b0}}, out_port_o};
    end else if (!me_i) rd_q <= '0;
  end

  assign rdata_o = rd_q;

  a_r2_out_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_out |=> $stable(out_port_o));
  a_r10_rdata_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> (rdata_o == '0));
  a_r10_rdata_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && me_i) |=> $stable(rdata_o));
endmodule

// File: rtl/hs_bus_target.sv
module hs_bus_target
  import hs_target_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 30,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       REG_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_WADDR = 30'h0123_4560
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic                rnw_i,
  input  logic                me_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                ack_o,
  input  logic [REG_W-1:0]    in_port_i,
  output logic [REG_W-1:0]    out_port_o
);
  hs_sel_e sel;
  logic    fire;

  hs_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_WADDR(BASE_WADDR), .IN_WOFS(0), .OUT_WOFS(1)
  ) u_dec (
    .me_i(me_i), .addr_i(addr_i), .sel_o(sel)
  );

  hs_handshake_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .me_i(me_i),
    .hit_i(sel != SEL_NONE), .fire_o(fire), .ack_o(ack_o)
  );

  hs_reg_file #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .ack_i(ack_o),
    .me_i(me_i), .rnw_i(rnw_i), .sel_i(sel), .be_i(be_i),
    .wdata_i(wdata_i), .in_port_i(in_port_i),
    .rdata_o(rdata_o), .out_port_o(out_port_o)
  );

  a_r7_in_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (me_i && !ack_o && !rnw_i && addr_i == BASE_WADDR) |=> $stable(out_port_o));
endmodule

// File: tb/hs_bus_target_tb.sv
module hs_bus_target_tb;
  localparam logic [29:0] BASE = 30'h0123_4560;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] addr = '0;
  logic [3:0]  be = '0;
  logic        rnw = 1'b0;
  logic        me = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  in_port = '0;
  logic [31:0] rdata;
  logic        ack;
  logic [7:0]  out_port;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hs_bus_target #(.BASE_WADDR(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .be_i(be), .rnw_i(rnw),
    .me_i(me), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .in_port_i(in_port), .out_port_o(out_port)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one four-phase access; hold = extra cycles with me high after ack
  task automatic xfer(input logic [29:0] a, input logic r, input logic [3:0] b,
                      input logic [31:0] wd, input int hold, input bit expect_ack,
                      input logic [31:0] exp_rd, input bit wiggle_in);
    @(negedge clk);
    addr = a; rnw = r; be = b; wdata = wd; me = 1'b1;
    @(negedge clk);
    chk(ack == expect_ack, expect_ack ? "R8 ack raise" : "R9 no ack", {31'b0, ack}, {31'b0, expect_ack});
    if (expect_ack && r) chk(rdata == exp_rd, "R3/R4 rdata", rdata, exp_rd);
    for (int i = 0; i < hold; i++) begin
      if (wiggle_in) in_port = in_port + 8'h5b;
      @(negedge clk);
      chk(ack == expect_ack, "R8 ack hold", {31'b0, ack}, {31'b0, expect_ack});
      if (expect_ack && r) chk(rdata == exp_rd, "R10 rdata frozen", rdata, exp_rd);
    end
    me = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R8 ack drop", {31'b0, ack}, 32'h0);
    chk(rdata == 32'h0, "R10 rdata idle zero", rdata, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_out;
    repeat (3) @(negedge clk);
    // R1
    chk(ack == 1'b0, "R1 ack reset", {31'b0, ack}, 32'h0);
    chk(rdata == 32'h0, "R1 rdata reset", rdata, 32'h0);
    chk(out_port == 8'h0, "R1 out reset", {24'b0, out_port}, 32'h0);
    rst_n = 1'b1;
    exp_out = 8'h00;

    // R2: me low, bus lines active
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr = BASE + 30'(i % 2); rnw = 1'b0; be = 4'hf; wdata = 32'hdead_be00 | i;
      @(negedge clk);
      chk(ack == 1'b0, "R2 no ack me low", {31'b0, ack}, 32'h0);
      chk(out_port == exp_out, "R2 out unchanged", {24'b0, out_port}, {24'b0, exp_out});
    end

    // R5/R6: every data value under every byte-enable pattern
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b < 16; b++) begin
        xfer(BASE + 30'd1, 1'b0, 4'(b), {~8'(v), 8'(v * 3), 8'(b), 8'(v)}, 0, 1'b1, 32'h0, 1'b0);
        if (b[0]) exp_out = 8'(v);
        chk(out_port == exp_out, b[0] ? "R5 write lane0" : "R6 write masked",
            {24'b0, out_port}, {24'b0, exp_out});
      end
    end

    // R4: read back output register
    xfer(BASE + 30'd1, 1'b0, 4'h1, 32'h0000_00a5, 0, 1'b1, 32'h0, 1'b0);
    exp_out = 8'ha5;
    xfer(BASE + 30'd1, 1'b1, 4'hf, 32'hffff_ffff, 2, 1'b1, {24'b0, exp_out}, 1'b0);

    // R3/R10: input sweep, input wiggled while ack held
    for (int v = 0; v < 256; v++) begin
      in_port = 8'(v);
      xfer(BASE, 1'b1, 4'(v), 32'h0, v % 4, 1'b1, {24'b0, 8'(v)}, 1'b1);
    end

    // R7: write to input word
    in_port = 8'h3c;
    xfer(BASE, 1'b0, 4'hf, 32'h0000_0077, 1, 1'b1, 32'h0, 1'b0);
    chk(out_port == exp_out, "R7 out unchanged", {24'b0, out_port}, {24'b0, exp_out});
    xfer(BASE, 1'b1, 4'h1, 32'h0, 0, 1'b1, 32'h0000_003c, 1'b0);

    // R9: near-miss addresses, long holds
    for (int k = 0; k < 30; k++) begin
      logic [29:0] a;
      a = BASE ^ (30'd1 << k);
      if (a != BASE && a != BASE + 30'd1) begin
        xfer(a, 1'b0, 4'hf, 32'h0000_0011, 3, 1'b0, 32'h0, 1'b0);
        chk(out_port == exp_out, "R9 out unchanged", {24'b0, out_port}, {24'b0, exp_out});
      end
    end
    xfer(BASE + 30'd2, 1'b1, 4'hf, 32'h0, 4, 1'b0, 32'h0, 1'b0);
    xfer(BASE - 30'd1, 1'b0, 4'hf, 32'h0, 4, 1'b0, 32'h0, 1'b0);
    chk(out_port == exp_out, "R9 out unchanged tail", {24'b0, out_port}, {24'b0, exp_out});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule